// File: doc/BRIEF.md
# Critical-Sub-Block Line Fill Splitter

This block sits between a cache's miss path and a DRAM request stream. Each cache-line fill it accepts is cut into fixed-size 16-byte sub-blocks, and each sub-block goes out as its own DRAM request carrying a one-bit priority. The sub-block that holds the missed word goes first and is marked critical. The rest of the line follows at normal priority, in wrap-around order starting after the critical piece. Several lines can be in flight together. All of their pending sub-blocks compete in one selection stage. Critical pieces beat normal ones, and among equal priority the line that was allocated earliest wins.

Each outstanding line is tracked in a miss-status entry. Inside the entry, every sub-block has a small state machine with three states: `SB_DONE` (idle or returned), `SB_WAIT` (pending issue) and `SB_FLIGHT` (issued, awaiting data). There are four transitions:
- ALLOC moves DONE to WAIT when a new line is taken.
- GRANT moves WAIT to FLIGHT on a request handshake.
- RETURN moves FLIGHT to DONE when that sub-block's data comes back.
- RAISE stays in WAIT and sets the high-priority bit when a later miss needs that piece.

An entry is busy while any of its sub-blocks is not in DONE. It becomes free as soon as its last sub-block returns.

A miss to a line that is already held makes no new entry. A miss to a line that is not held needs a free entry. With all entries busy, such a miss is stalled through `miss_ready`.

Top module: `subblk_splitter`

## Requirements
- R1: After reset, `req_valid` is 0 and `miss_ready` is 1.
- R2: A miss accepted for a line not held gets an entry. From the next cycle, its critical sub-block is offered with `req_prio`=1. `req_addr` is the sub-block address `{line, sub}`: the line address in the upper bits and the 2-bit sub-block index (byte offset / 16) in the low bits.
- R3: After the critical piece, a line's remaining sub-blocks are issued at `req_prio`=0 in wrap-around order: crit+1, crit+2, crit+3 (mod 4).
- R4: While any sub-block of any line is pending at priority 1, no priority-0 sub-block is issued.
- R5: Among pending sub-blocks of equal priority, those of the earliest-allocated line are issued first.
- R6: A miss to a held line whose needed sub-block is still pending raises that sub-block to priority 1. It then goes out next in its class. A miss to a held line whose sub-block was already issued has no effect, and neither kind of hit creates a new entry.
- R7: `miss_ready` is 1 when the miss line is held or some entry is free. It is 0 for a line not held while all 4 entries are busy.
- R8: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 on the next cycle.
- R9: A return whose address matches an in-flight sub-block completes it. Any other return is ignored. An entry becomes free the cycle after its fourth sub-block completes.
- R10: Every sub-block of an allocated line is issued exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Miss can be accepted this cycle |
| miss_line | input | 26 | Line address of the miss |
| miss_sub | input | 2 | Index of the sub-block holding the missed word |
| req_valid | output | 1 | A sub-block request is offered |
| req_ready | input | 1 | DRAM side takes the request |
| req_addr | output | 28 | Sub-block address `{line, sub}` |
| req_prio | output | 1 | 1 = critical, 0 = normal |
| ret_valid | input | 1 | A sub-block's data has returned |
| ret_addr | input | 28 | Sub-block address of the returned data |

## Verification
A sub-block state that goes wrong shows up at the DRAM port on the very next grant. A lost WAIT state drops a piece from the stream. A stuck one repeats it or keeps `req_valid` high after the line should be drained. A wrong high-priority bit or age order reorders the stream at the first point where two candidates compete, so the directed sequences compare every offered address and priority in turn. A wrong busy indication surfaces through `miss_ready` in the same cycle that a new-line miss is presented. The tests hold all entries full, free one with a final return, and show the stall lifting one cycle later.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
    typedef enum logic [1:0] {
        SB_DONE   = 2'd0,
        SB_WAIT   = 2'd1,
        SB_FLIGHT = 2'd2
    } sb_state_e;
endpackage

// File: rtl/sbs_entry.sv
`timescale 1ns/1ps
module sbs_entry
    import sbs_pkg::*;
#(
    parameter int LINE_AW = 26,
    parameter int SUBS    = 4,
    parameter int SUB_W   = $clog2(SUBS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc,
    input  logic [LINE_AW-1:0] alloc_line,
    input  logic [SUB_W-1:0]   alloc_sub,
    input  logic               raise,
    input  logic [SUB_W-1:0]   raise_sub,
    input  logic               grant,
    input  logic [SUB_W-1:0]   grant_sub,
    input  logic               ret,
    input  logic [SUB_W-1:0]   ret_sub,
    output logic               busy,
    output logic [LINE_AW-1:0] line,
    output logic [SUB_W-1:0]   crit,
    output logic [SUBS-1:0]    pend,
    output logic [SUBS-1:0]    hi,
    output logic [SUBS-1:0]    fly
);
    sb_state_e          sb_q [SUBS];
    sb_state_e          sb_d [SUBS];
    logic [SUBS-1:0]    hi_q, hi_d;
    logic [LINE_AW-1:0] line_q;
    logic [SUB_W-1:0]   crit_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SUBS; s++) sb_q[s] <= SB_DONE;
            hi_q   <= '0;
            line_q <= '0;
            crit_q <= '0;
        end else begin
            for (int s = 0; s < SUBS; s++) sb_q[s] <= sb_d[s];
            hi_q <= hi_d;
            if (alloc) begin
                line_q <= alloc_line;
                crit_q <= alloc_sub;
            end
        end
    end

    // per-sub-block transitions: ALLOC, GRANT, RETURN, RAISE
    always_comb begin
        for (int s = 0; s < SUBS; s++) begin
            sb_d[s] = sb_q[s];
            hi_d[s] = hi_q[s];
            unique case (sb_q[s])
                SB_DONE: begin
                    if (alloc) begin
                        sb_d[s] = SB_WAIT;
                        hi_d[s] = (alloc_sub == SUB_W'(s));
                    end
                end
                SB_WAIT: begin
                    if (grant && grant_sub == SUB_W'(s)) begin
                        sb_d[s] = SB_FLIGHT;
                        hi_d[s] = 1'b0;
                    end else if (raise && raise_sub == SUB_W'(s)) begin
                        hi_d[s] = 1'b1;
                    end
                end
                SB_FLIGHT: begin
                    if (ret && ret_sub == SUB_W'(s)) sb_d[s] = SB_DONE;
                end
                default: sb_d[s] = SB_DONE;
            endcase
        end
    end

    // outputs
    always_comb begin
        for (int s = 0; s < SUBS; s++) begin
            pend[s] = (sb_q[s] == SB_WAIT);
            fly[s]  = (sb_q[s] == SB_FLIGHT);
        end
        hi   = hi_q;
        busy = |(pend | fly);
        line = line_q;
        crit = crit_q;
    end

    // R7
    alloc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !busy);
    // R10
    grant_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> pend[grant_sub]);
    // R9
    ret_fly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret |-> fly[ret_sub]);
endmodule

// File: rtl/sbs_age.sv
`timescale 1ns/1ps
module sbs_age #(
    parameter int NENT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NENT-1:0]            alloc_vec,
    input  logic [NENT-1:0]            busy,
    output logic [NENT-1:0][NENT-1:0]  older
);
    logic [NENT-1:0][NENT-1:0] older_q, older_d;

    always_ff @(posedge clk) begin
        if (!rst_n) older_q <= '0;
        else        older_q <= older_d;
    end

    always_comb begin
        older_d = older_q;
        for (int k = 0; k < NENT; k++) begin
            if (alloc_vec[k]) begin
                for (int j = 0; j < NENT; j++) begin
                    older_d[k][j] = 1'b0;
                    if (j != k) older_d[j][k] = busy[j];
                end
            end
        end
    end

    assign older = older_q;

    // R5
    alloc_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_vec));

    for (genvar i = 0; i < NENT; i++) begin : g_row
        for (genvar j = i + 1; j < NENT; j++) begin : g_col
            // R5
            order_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (busy[i] && busy[j]) |-> (older_q[i][j] != older_q[j][i]));
        end
    end
endmodule

// File: rtl/sbs_pick.sv
`timescale 1ns/1ps
module sbs_pick #(
    parameter int NENT  = 4,
    parameter int SUBS  = 4,
    parameter int SUB_W = $clog2(SUBS),
    parameter int ENT_W = $clog2(NENT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NENT-1:0][SUBS-1:0]  pend,
    input  logic [NENT-1:0][SUBS-1:0]  hi,
    input  logic [NENT-1:0][SUB_W-1:0] crit,
    input  logic [NENT-1:0][NENT-1:0]  older,
    output logic                       gnt_valid,
    output logic [ENT_W-1:0]           gnt_ent,
    output logic [SUB_W-1:0]           gnt_sub,
    output logic                       gnt_hi
);
    logic [NENT-1:0]            has_hi, has_any, cand, win;
    logic [NENT-1:0][SUB_W-1:0] hsub, asub;
    logic                       use_hi;

    always_comb begin
        logic [SUB_W-1:0] s;
        for (int e = 0; e < NENT; e++) begin
            has_hi[e]  = |(pend[e] & hi[e]);
            has_any[e] = |pend[e];
            hsub[e]    = '0;
            asub[e]    = '0;
            // lowest wrap distance from the critical piece wins
            for (int k = SUBS - 1; k >= 0; k--) begin
                s = crit[e] + SUB_W'(k);
                if (pend[e][s] && hi[e][s]) hsub[e] = s;
                if (pend[e][s])             asub[e] = s;
            end
        end
        use_hi = |has_hi;
        cand   = use_hi ? has_hi : has_any;
        for (int e = 0; e < NENT; e++) begin
            win[e] = cand[e];
            for (int j = 0; j < NENT; j++) begin
                if (j != e && cand[j] && !older[e][j]) win[e] = 1'b0;
            end
        end
        gnt_ent = '0;
        for (int e = 0; e < NENT; e++) begin
            if (win[e]) gnt_ent = ENT_W'(e);
        end
        gnt_valid = |has_any;
        gnt_sub   = use_hi ? hsub[gnt_ent] : asub[gnt_ent];
        gnt_hi    = use_hi;
    end

    // R5
    win_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> $onehot(win));
endmodule

// File: rtl/subblk_splitter.sv
`timescale 1ns/1ps
module subblk_splitter #(
    parameter int LINE_AW    = 26,
    parameter int LINE_BYTES = 64,
    parameter int SUB_BYTES  = 16,
    parameter int NENT       = 4,
    localparam int SUBS      = LINE_BYTES / SUB_BYTES,
    localparam int SUB_W     = $clog2(SUBS),
    localparam int ENT_W     = $clog2(NENT),
    localparam int SA_W      = LINE_AW + SUB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    output logic               miss_ready,
    input  logic [LINE_AW-1:0] miss_line,
    input  logic [SUB_W-1:0]   miss_sub,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [SA_W-1:0]    req_addr,
    output logic               req_prio,
    input  logic               ret_valid,
    input  logic [SA_W-1:0]    ret_addr
);
    logic [NENT-1:0]               busy_a, hit, alloc_vec, raise_vec, grant_vec, ret_vec;
    logic [NENT-1:0][LINE_AW-1:0]  line_a;
    logic [NENT-1:0][SUB_W-1:0]    crit_a;
    logic [NENT-1:0][SUBS-1:0]     pend_a, hi_a, fly_a;
    logic [NENT-1:0][NENT-1:0]     older;
    logic [ENT_W-1:0]              free_ent, gnt_ent;
    logic [SUB_W-1:0]              gnt_sub;
    logic                          gnt_valid, gnt_hi, any_hit, accept;
    logic [LINE_AW-1:0]            ret_line;
    logic [SUB_W-1:0]              ret_sub;

    assign ret_line = ret_addr[SA_W-1:SUB_W];
    assign ret_sub  = ret_addr[SUB_W-1:0];

    always_comb begin
        free_ent = '0;
        for (int e = NENT - 1; e >= 0; e--) begin
            if (!busy_a[e]) free_ent = ENT_W'(e);
        end
        for (int e = 0; e < NENT; e++) begin
            hit[e] = busy_a[e] && (line_a[e] == miss_line);
        end
        any_hit    = |hit;
        miss_ready = any_hit || !(&busy_a);
        accept     = miss_valid && miss_ready;
        for (int e = 0; e < NENT; e++) begin
            alloc_vec[e] = accept && !any_hit && (free_ent == ENT_W'(e));
            raise_vec[e] = accept && hit[e];
            grant_vec[e] = gnt_valid && req_ready && (gnt_ent == ENT_W'(e));
            ret_vec[e]   = ret_valid && busy_a[e] && (line_a[e] == ret_line)
                           && fly_a[e][ret_sub];
        end
    end

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        sbs_entry #(.LINE_AW(LINE_AW), .SUBS(SUBS), .SUB_W(SUB_W)) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc      (alloc_vec[e]),
            .alloc_line (miss_line),
            .alloc_sub  (miss_sub),
            .raise      (raise_vec[e]),
            .raise_sub  (miss_sub),
            .grant      (grant_vec[e]),
            .grant_sub  (gnt_sub),
            .ret        (ret_vec[e]),
            .ret_sub    (ret_sub),
            .busy       (busy_a[e]),
            .line       (line_a[e]),
            .crit       (crit_a[e]),
            .pend       (pend_a[e]),
            .hi         (hi_a[e]),
            .fly        (fly_a[e])
        );
    end

    sbs_age #(.NENT(NENT)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_vec (alloc_vec),
        .busy      (busy_a),
        .older     (older)
    );

    sbs_pick #(.NENT(NENT), .SUBS(SUBS), .SUB_W(SUB_W), .ENT_W(ENT_W)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend_a),
        .hi        (hi_a),
        .crit      (crit_a),
        .older     (older),
        .gnt_valid (gnt_valid),
        .gnt_ent   (gnt_ent),
        .gnt_sub   (gnt_sub),
        .gnt_hi    (gnt_hi)
    );

    assign req_valid = gnt_valid;
    assign req_addr  = {line_a[gnt_ent], gnt_sub};
    assign req_prio  = gnt_hi;

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid);
    // R7
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !miss_ready) |-> (&busy_a));
    // R6
    uniq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    // R10
    issue_fly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> fly_a[$past(gnt_ent)][$past(gnt_sub)]);
endmodule

// File: tb/subblk_splitter_tb.sv
`timescale 1ns/1ps
module subblk_splitter_tb;
    localparam int LAW  = 26;
    localparam int SW   = 2;
    localparam int SAW  = LAW + SW;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           miss_valid, miss_ready, req_valid, req_ready, req_prio, ret_valid;
    logic [LAW-1:0] miss_line;
    logic [SW-1:0]  miss_sub;
    logic [SAW-1:0] req_addr, ret_addr;
    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    subblk_splitter u_dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_line(miss_line), .miss_sub(miss_sub),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_prio(req_prio),
        .ret_valid(ret_valid), .ret_addr(ret_addr)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    task automatic miss(input logic [LAW-1:0] ln, input logic [SW-1:0] sb);
        miss_valid = 1'b1; miss_line = ln; miss_sub = sb;
        #1;
        chk(miss_ready == 1'b1, "R7 miss_ready", 64'(miss_ready), 64'd1);
        @(posedge clk); @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic take(input logic [LAW-1:0] ln, input logic [SW-1:0] sb, input logic p, input string rq);
        logic [SAW-1:0] ea;
        ea = {ln, sb};
        chk(req_valid && req_addr == ea && req_prio == p, rq,
            {34'd0, req_valid, req_prio, req_addr}, {34'd0, 1'b1, p, ea});
        req_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        req_ready = 1'b0;
    endtask

    task automatic ret(input logic [LAW-1:0] ln, input logic [SW-1:0] sb);
        ret_valid = 1'b1; ret_addr = {ln, sb};
        @(posedge clk); @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic ret_line(input logic [LAW-1:0] ln);
        for (int s = 0; s < 4; s++) ret(ln, SW'(s));
    endtask

    task automatic idle(input string rq);
        chk(req_valid == 1'b0, rq, 64'(req_valid), 64'd0);
    endtask

    task automatic t_reset();
        chk(req_valid == 1'b0, "R1 req_valid", 64'(req_valid), 64'd0);
        miss_valid = 1'b1; miss_line = 26'h10; #1;
        chk(miss_ready == 1'b1, "R1 miss_ready", 64'(miss_ready), 64'd1);
        miss_valid = 1'b0;
    endtask

    task automatic t_single();
        miss(26'h100, 2'd2);
        take(26'h100, 2'd2, 1'b1, "R2 critical first");
        take(26'h100, 2'd3, 1'b0, "R3 wrap 1");
        take(26'h100, 2'd0, 1'b0, "R3 wrap 2");
        take(26'h100, 2'd1, 1'b0, "R3 wrap 3");
        idle("R10 line drained");
        ret_line(26'h100);
    endtask

    task automatic t_two_lines();
        miss(26'h0B0, 2'd1);
        miss(26'h0C0, 2'd3);
        take(26'h0B0, 2'd1, 1'b1, "R4 crit B");
        take(26'h0C0, 2'd3, 1'b1, "R4 crit C before normal B");
        take(26'h0B0, 2'd2, 1'b0, "R5 older B");
        take(26'h0B0, 2'd3, 1'b0, "R5 older B");
        take(26'h0B0, 2'd0, 1'b0, "R5 older B");
        take(26'h0C0, 2'd0, 1'b0, "R5 newer C");
        take(26'h0C0, 2'd1, 1'b0, "R5 newer C");
        take(26'h0C0, 2'd2, 1'b0, "R5 newer C");
        idle("R10 two drained");
        ret_line(26'h0B0);
        ret_line(26'h0C0);
    endtask

    task automatic t_raise();
        miss(26'h0D0, 2'd0);
        take(26'h0D0, 2'd0, 1'b1, "R2 crit D");
        miss(26'h0D0, 2'd2);
        take(26'h0D0, 2'd2, 1'b1, "R6 raised sub");
        miss(26'h0D0, 2'd0);
        take(26'h0D0, 2'd1, 1'b0, "R6 rest D");
        take(26'h0D0, 2'd3, 1'b0, "R6 rest D");
        idle("R6 no new entry from hits");
        miss(26'h0E0, 2'd0);
        miss(26'h0F0, 2'd0);
        take(26'h0E0, 2'd0, 1'b1, "R4 crit E");
        take(26'h0F0, 2'd0, 1'b1, "R4 crit F");
        miss(26'h0F0, 2'd3);
        take(26'h0F0, 2'd3, 1'b1, "R6 raised beats older normal");
        take(26'h0E0, 2'd1, 1'b0, "R5 E");
        take(26'h0E0, 2'd2, 1'b0, "R5 E");
        take(26'h0E0, 2'd3, 1'b0, "R5 E");
        take(26'h0F0, 2'd1, 1'b0, "R5 F");
        take(26'h0F0, 2'd2, 1'b0, "R5 F");
        idle("R10 raise drained");
        ret_line(26'h0D0);
        ret_line(26'h0E0);
        ret_line(26'h0F0);
    endtask

    task automatic t_full();
        for (int g = 0; g < 4; g++) miss(26'h200 + LAW'(g), 2'd0);
        miss_valid = 1'b1; miss_line = 26'h300; miss_sub = 2'd1; #1;
        chk(miss_ready == 1'b0, "R7 stall when full", 64'(miss_ready), 64'd0);
        miss_line = 26'h201; miss_sub = 2'd2; #1;
        chk(miss_ready == 1'b1, "R7 hit accepted when full", 64'(miss_ready), 64'd1);
        @(posedge clk); @(negedge clk);
        miss_valid = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk); @(negedge clk);
            chk(req_valid == 1'b1, "R8 held without ready", 64'(req_valid), 64'd1);
        end
        take(26'h200, 2'd0, 1'b1, "R5 G0 crit");
        take(26'h201, 2'd0, 1'b1, "R5 G1 crit");
        take(26'h201, 2'd2, 1'b1, "R6 G1 raised");
        take(26'h202, 2'd0, 1'b1, "R5 G2 crit");
        take(26'h203, 2'd0, 1'b1, "R5 G3 crit");
        for (int s = 1; s < 4; s++) take(26'h200, SW'(s), 1'b0, "R3 G0");
        take(26'h201, 2'd1, 1'b0, "R10 G1 once");
        take(26'h201, 2'd3, 1'b0, "R10 G1 once");
        for (int s = 1; s < 4; s++) take(26'h202, SW'(s), 1'b0, "R3 G2");
        for (int s = 1; s < 4; s++) take(26'h203, SW'(s), 1'b0, "R3 G3");
        idle("R10 full drained");
        ret(26'h200, 2'd0); ret(26'h200, 2'd1); ret(26'h200, 2'd2);
        ret(26'h200, 2'd1);
        miss_valid = 1'b1; miss_line = 26'h300; miss_sub = 2'd1; #1;
        chk(miss_ready == 1'b0, "R9 stray return ignored", 64'(miss_ready), 64'd0);
        miss_valid = 1'b0;
        ret(26'h200, 2'd3);
        miss_valid = 1'b1; miss_line = 26'h300; miss_sub = 2'd1; #1;
        chk(miss_ready == 1'b1, "R9 entry freed", 64'(miss_ready), 64'd1);
        @(posedge clk); @(negedge clk);
        miss_valid = 1'b0;
        ret(26'h300, 2'd2);
        take(26'h300, 2'd1, 1'b1, "R2 reused entry");
        take(26'h300, 2'd2, 1'b0, "R9 early return ignored");
        take(26'h300, 2'd3, 1'b0, "R3 H");
        take(26'h300, 2'd0, 1'b0, "R3 H");
        idle("R10 H drained");
        ret_line(26'h300);
        for (int g = 1; g < 4; g++) ret_line(26'h200 + LAW'(g));
        for (int g = 0; g < 4; g++) miss(26'h400 + LAW'(g), 2'd3);
        take(26'h400, 2'd3, 1'b1, "R9 all entries reusable");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; miss_valid = 1'b0; miss_line = '0; miss_sub = '0;
        req_ready = 1'b0; ret_valid = 1'b0; ret_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_two_lines();
        t_raise();
        t_full();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule